// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This receiver turns a two-channel serial audio stream into parallel 16-bit sample pairs in the master clock domain. The stream consists of a bit clock, a left/right framing clock, an optional word clock and one data line. Data arrives most significant bit first as two's complement words of 4 to 16 bits per channel. A 2-bit format select picks one of four framings, and a polarity input picks which bit clock edge samples the data. All serial lines are oversampled by the master clock through two-flop synchronizers, and edges are detected in the master domain. The bit clock may stop between words. The left/right clock must keep running, because its edges close every slot.

A frame state machine follows the left/right clock. It has four states. ST_HUNT waits for the first falling left/right edge after reset, and that edge moves it to ST_WAIT_L. In ST_WAIT_L, a rising edge opens a clean left slot and moves to ST_LEFT. In ST_LEFT, a falling edge stores the left word and moves to ST_RIGHT. In ST_RIGHT, a rising edge publishes the pair, pulses the valid output and returns to ST_LEFT. Every left/right edge clears the capture word and restarts the bit position. In the word clock format, the position instead waits for a rising word clock edge.

Top module: `serial_audio_rx`

## Requirements
- R1: Bits are captured MSB first, so the first captured bit lands in bit 15 of the output word. The left word is the one received while the left/right clock is high, and the right word is the one received while it is low.
- R2: A word shorter than 16 bits leaves zeros in the unreceived low positions. Slot bits after the 16th captured bit are ignored.
- R3: With `bclk_inv` = 0, data is sampled on rising bit clock edges. With `bclk_inv` = 1, data is sampled on falling edges.
- R4: With `fmt_sel` = 2'b00, the MSB is the bit sampled at the first active edge after a left/right transition.
- R5: With `fmt_sel` = 2'b01, the first bit after a left/right transition is ignored, and the MSB is the bit sampled at the second active edge.
- R6: With `fmt_sel` = 2'b10, the first 16 bits of a slot are ignored, and the MSB is the bit sampled at the 17th active edge.
- R7: With `fmt_sel` = 2'b11, bits before a rising word clock edge are ignored, and the MSB is the bit sampled at the first active edge after that rising edge. In every other format, the word clock has no effect.
- R8: `pair_valid` is a one-cycle pulse raised after the rising left/right edge that ends a low (right) slot. It carries the left word of the preceding high slot and the right word of that low slot.
- R9: During and after reset, `pair_valid`, `left_out` and `right_out` are zero. No pair is produced until a falling left/right edge has been followed by a complete high slot and a complete low slot.
- R10: If the bit clock stops partway through a slot, the left/right edge still closes the slot, and the positions not received read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_in | input | 1 | Serial bit clock, may be gated |
| lrclk_in | input | 1 | Left/right framing clock; high selects left |
| wclk_in | input | 1 | Word clock, rising edge starts a word in format 2'b11 |
| sdata_in | input | 1 | Serial data, MSB first |
| fmt_sel | input | 2 | Framing format: 00, 01, 10, 11 as in R4 to R7 |
| bclk_inv | input | 1 | 0 samples on rising bit clock edges, 1 on falling edges |
| pair_valid | output | 1 | One-cycle strobe for a new sample pair |
| left_out | output | 16 | Left sample, MSB aligned |
| right_out | output | 16 | Right sample, MSB aligned |

## Verification
The hardest situation to reach is a slot that the left/right clock closes while the bit clock is frozen. Every normal frame keeps the bit clock running, so a slot only ends this way when the bench deliberately stops it. The bench reaches this case by sending a few bits and then holding the bit clock at its idle level while it moves the left/right clock alone, across both the left and the right slots. The ignored-bit cases are also driven on purpose. The bench places ones in every ignored slot position and sends word clock pulses in formats that must not respond to them, so any of these bits leaking into a word would show up in the published pair.

// File: rtl/sarx_pkg.sv
package sarx_pkg;

    typedef enum logic [1:0] {
        FMT_LJ     = 2'b00,
        FMT_LJ_DLY = 2'b01,
        FMT_RJ     = 2'b10,
        FMT_WCLK   = 2'b11
    } fmt_e;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_WAIT_L,
        ST_LEFT,
        ST_RIGHT
    } frame_st_e;

endpackage

// File: rtl/sarx_sync.sv
module sarx_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);

    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= d_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign q_out = stg[STAGES-1];

endmodule

// File: rtl/sarx_capture.sv
module sarx_capture
    import sarx_pkg::*;
#(
    parameter int WORD_W   = 16,
    parameter int RJ_DELAY = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  fmt_e              fmt,
    input  logic              bclk_inv,
    input  logic              bclk_s,
    input  logic              wclk_s,
    input  logic              sdata_s,
    input  logic              slot_start,
    output logic [WORD_W-1:0] word_o
);

    localparam int POS_MAX = RJ_DELAY + WORD_W;
    localparam int POS_W   = $clog2(POS_MAX + 1);
    localparam int IDX_W   = $clog2(WORD_W);

    logic             bclk_q, wclk_q;
    logic             bit_act, wclk_rise;
    logic [POS_W-1:0] pos, off, k;
    logic             cap_en;
    logic [IDX_W-1:0] cap_idx;

    assign bit_act   = bclk_inv ? (bclk_q & ~bclk_s) : (~bclk_q & bclk_s);
    assign wclk_rise = ~wclk_q & wclk_s;

    always_comb begin
        unique case (fmt)
            FMT_LJ:     off = '0;
            FMT_LJ_DLY: off = POS_W'(1);
            FMT_RJ:     off = POS_W'(RJ_DELAY);
            FMT_WCLK:   off = '0;
        endcase
        k       = pos - off;
        cap_en  = bit_act && (pos >= off) && (k < POS_W'(WORD_W));
        cap_idx = IDX_W'(WORD_W - 1) - k[IDX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bclk_q <= 1'b0;
            wclk_q <= 1'b0;
            pos    <= POS_W'(POS_MAX);
            word_o <= '0;
        end else begin
            bclk_q <= bclk_s;
            wclk_q <= wclk_s;
            if (slot_start) begin
                word_o <= '0;
                pos    <= (fmt == FMT_WCLK) ? POS_W'(POS_MAX) : '0;
            end else if (fmt == FMT_WCLK && wclk_rise) begin
                pos <= '0;
            end else if (bit_act) begin
                if (cap_en) word_o[cap_idx] <= sdata_s;
                if (pos != POS_W'(POS_MAX)) pos <= pos + 1'b1;
            end
        end
    end

    // R2: every new slot starts from an all-zero word
    a_r2_clear_on_slot: assert property (@(posedge clk) disable iff (!rst_n)
        slot_start |=> (word_o == '0));

    // R7: outside the word clock format the word clock touches nothing
    a_r7_wclk_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt != FMT_WCLK && !slot_start && !bit_act) |=> ($stable(word_o) && $stable(pos)));

    // R3: the word only changes on an active bit clock edge or a slot start
    a_r3_hold_between_edges: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_act && !slot_start) |=> $stable(word_o));

endmodule

// File: rtl/sarx_frame.sv
module sarx_frame
    import sarx_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lr_s,
    input  logic [WORD_W-1:0] word_i,
    output logic              slot_start,
    output logic              pair_valid,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o
);

    frame_st_e         state, state_nx;
    logic              lr_q, lr_rise, lr_fall;
    logic [WORD_W-1:0] left_hold;

    assign lr_rise    = lr_s & ~lr_q;
    assign lr_fall    = ~lr_s & lr_q;
    assign slot_start = lr_rise | lr_fall;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            lr_q  <= 1'b0;
        end else begin
            state <= state_nx;
            lr_q  <= lr_s;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HUNT:   if (lr_fall) state_nx = ST_WAIT_L;
            ST_WAIT_L: if (lr_rise) state_nx = ST_LEFT;
            ST_LEFT:   if (lr_fall) state_nx = ST_RIGHT;
            ST_RIGHT:  if (lr_rise) state_nx = ST_LEFT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pair_valid <= 1'b0;
            left_hold  <= '0;
            left_o     <= '0;
            right_o    <= '0;
        end else begin
            pair_valid <= 1'b0;
            unique case (state)
                ST_LEFT: if (lr_fall) left_hold <= word_i;
                ST_RIGHT: if (lr_rise) begin
                    left_o     <= left_hold;
                    right_o    <= word_i;
                    pair_valid <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R8: the strobe lasts a single cycle
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |=> !pair_valid);

    // R8: a pair is only published when leaving the right slot
    a_r8_after_right: assert property (@(posedge clk) disable iff (!rst_n)
        pair_valid |-> ($past(state) == ST_RIGHT));

    // R9: no pair while still aligning to the framing clock
    a_r9_hunt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT || state == ST_WAIT_L) |-> !pair_valid);

endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
    import sarx_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int RJ_DELAY    = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bclk_in,
    input  logic              lrclk_in,
    input  logic              wclk_in,
    input  logic              sdata_in,
    input  logic [1:0]        fmt_sel,
    input  logic              bclk_inv,
    output logic              pair_valid,
    output logic [WORD_W-1:0] left_out,
    output logic [WORD_W-1:0] right_out
);

    logic [3:0]        lines_s;
    logic              slot_start;
    logic [WORD_W-1:0] word;

    sarx_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({sdata_in, wclk_in, lrclk_in, bclk_in}),
        .q_out (lines_s)
    );

    sarx_capture #(.WORD_W(WORD_W), .RJ_DELAY(RJ_DELAY)) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .fmt        (fmt_e'(fmt_sel)),
        .bclk_inv   (bclk_inv),
        .bclk_s     (lines_s[0]),
        .wclk_s     (lines_s[2]),
        .sdata_s    (lines_s[3]),
        .slot_start (slot_start),
        .word_o     (word)
    );

    sarx_frame #(.WORD_W(WORD_W)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .lr_s       (lines_s[1]),
        .word_i     (word),
        .slot_start (slot_start),
        .pair_valid (pair_valid),
        .left_o     (left_out),
        .right_o    (right_out)
    );

endmodule

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk_in = 1'b0, lrclk_in = 1'b0, wclk_in = 1'b0, sdata_in = 1'b0;
    logic [1:0]  fmt_sel = 2'b00;
    logic        bclk_inv = 1'b0;
    logic        pair_valid;
    logic [15:0] left_out, right_out;

    int checks = 0;
    int errors = 0;
    int got_cnt = 0;
    int n_exp = 0;
    logic [15:0] exp_l [16];
    logic [15:0] exp_r [16];
    string       exp_tag [16];

    always #10 clk = ~clk;

    serial_audio_rx u_serial_audio_rx (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .lrclk_in(lrclk_in),
        .wclk_in(wclk_in), .sdata_in(sdata_in), .fmt_sel(fmt_sel),
        .bclk_inv(bclk_inv), .pair_valid(pair_valid),
        .left_out(left_out), .right_out(right_out)
    );

    typedef struct packed {
        logic [1:0]  fmt;
        logic        inv;
        logic [4:0]  nbits;
        logic [5:0]  slot;
        logic [15:0] l;
        logic [15:0] r;
    } vec_t;

    localparam int NVEC = 9;
    localparam vec_t VECS [NVEC] = '{
        '{2'b00, 1'b0, 5'd16, 6'd16, 16'h8001, 16'h7FFE},  // R4 R1
        '{2'b00, 1'b1, 5'd16, 6'd20, 16'hA5C3, 16'h5A3C},  // R4 R3 R2 (bits past 16th)
        '{2'b01, 1'b0, 5'd16, 6'd18, 16'h1234, 16'hFEDC},  // R5
        '{2'b01, 1'b1, 5'd12, 6'd16, 16'h0ABC, 16'h0F01},  // R5 R2 zero fill
        '{2'b10, 1'b0, 5'd16, 6'd32, 16'hC0DE, 16'hBEEF},  // R6
        '{2'b10, 1'b1, 5'd8,  6'd32, 16'h00A7, 16'h0055},  // R6 R2
        '{2'b11, 1'b0, 5'd16, 6'd24, 16'h4321, 16'h8765},  // R7
        '{2'b11, 1'b1, 5'd4,  6'd12, 16'h0009, 16'h0006},  // R7 R2
        '{2'b00, 1'b0, 5'd4,  6'd6,  16'h000F, 16'h0008}   // R4 short slot R2
    };

    function automatic int fmt_off(input logic [1:0] f);
        case (f)
            2'b00:   return 0;
            2'b01:   return 1;
            2'b10:   return 16;
            default: return 2;   // bench raises the word clock at position 2
        endcase
    endfunction

    function automatic logic bit_of(input logic [1:0] f, input int p, input int n,
                                    input logic [15:0] w);
        int k;
        if (p < fmt_off(f)) return 1'b1;   // ignored lead-in, driven as ones
        k = p - fmt_off(f);
        if (k < n)  return w[n-1-k];
        if (k < 16) return 1'b0;
        return 1'b1;                        // beyond 16th bit, must be ignored
    endfunction

    function automatic logic wc_of(input logic [1:0] f, input int p);
        if (f == 2'b11) return (p == 2 || p == 3);
        return (p == 5);                    // stray pulse, must be ignored
    endfunction

    task automatic bit_cycle(input logic inv, input logic lr_v, input logic d, input logic wc);
        @(negedge clk);
        bclk_in = inv; lrclk_in = lr_v; sdata_in = d; wclk_in = wc;
        repeat (8) @(negedge clk);
        bclk_in = ~inv;
        repeat (8) @(negedge clk);
    endtask

    task automatic lr_only(input logic v);
        @(negedge clk);
        lrclk_in = v;
        repeat (40) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input logic [15:0] act,
                         input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic expect_pair(input logic [15:0] l, input logic [15:0] r, input string tag);
        exp_l[n_exp] = l; exp_r[n_exp] = r; exp_tag[n_exp] = tag;
        n_exp++;
    endtask

    task automatic send_frame(input vec_t v);
        @(negedge clk);
        fmt_sel = v.fmt; bclk_inv = v.inv;
        expect_pair(v.l << (16 - int'(v.nbits)), v.r << (16 - int'(v.nbits)),
                    $sformatf("R1 R8 R2 R3 fmt%b inv%b", v.fmt, v.inv));
        for (int p = 0; p < int'(v.slot); p++)
            bit_cycle(v.inv, 1'b1, bit_of(v.fmt, p, int'(v.nbits), v.l), wc_of(v.fmt, p));
        for (int p = 0; p < int'(v.slot); p++)
            bit_cycle(v.inv, 1'b0, bit_of(v.fmt, p, int'(v.nbits), v.r), wc_of(v.fmt, p));
    endtask

    // pair monitor: R8 content and one pulse per frame
    always @(negedge clk) begin
        if (rst_n && pair_valid) begin
            if (got_cnt >= n_exp) begin
                check(1'b0, "R9 unexpected pair", left_out, 16'h0000);
            end else begin
                check(left_out == exp_l[got_cnt],
                      {exp_tag[got_cnt], " left"}, left_out, exp_l[got_cnt]);
                check(right_out == exp_r[got_cnt],
                      {exp_tag[got_cnt], " right"}, right_out, exp_r[got_cnt]);
            end
            got_cnt++;
        end
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d pairs", got_cnt, n_exp);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : stim
        lrclk_in = 1'b1;   // high during reset: the first seen edge is a rise
        repeat (5) @(negedge clk);
        // R9: reset state
        check(pair_valid == 1'b0, "R9 reset valid", {15'd0, pair_valid}, 16'h0000);
        check(left_out == 16'h0000, "R9 reset left", left_out, 16'h0000);
        check(right_out == 16'h0000, "R9 reset right", right_out, 16'h0000);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        // partial slots before alignment must not publish anything (R9)
        for (int p = 0; p < 5; p++) bit_cycle(1'b0, 1'b1, 1'b1, 1'b0);
        for (int p = 0; p < 5; p++) bit_cycle(1'b0, 1'b0, 1'b1, 1'b0);
        check(got_cnt == 0, "R9 no pair before alignment", 16'(got_cnt), 16'h0000);

        // table walk: each frame is published at the start of the next one
        for (int i = 0; i < NVEC; i++) send_frame(VECS[i]);

        // R10: gated bit clock, slots closed by the framing clock alone
        @(negedge clk);
        fmt_sel = 2'b00; bclk_inv = 1'b0;
        expect_pair(16'hA500, 16'hB400, "R10 gated bclk");
        for (int p = 0; p < 8; p++) bit_cycle(1'b0, 1'b1, p[0] ? (p == 5 || p == 7) : (p == 0 || p == 2), 1'b0);
        lr_only(1'b0);
        for (int p = 0; p < 6; p++) bit_cycle(1'b0, 1'b0, (p == 0 || p == 2 || p == 3 || p == 5), 1'b0);
        lr_only(1'b1);
        repeat (20) @(negedge clk);

        check(got_cnt == n_exp, "R8 R9 pair count", 16'(got_cnt), 16'(n_exp));
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule